// File: doc/BRIEF.md
# Memory-Mapped Machine Timer and Byte Transmit Registers

This block is the peripheral register set for a small 32-bit core platform. It answers word requests in the `0x10xx_xxxx` address window and holds four registers: a free-running 32-bit machine time counter, a 32-bit compare value, a transmit status word and a transmit data word. Software reaches all of them with ordinary loads and stores.

The comparison of time against the compare value drives `timer_irq`, a level that goes straight to the machine timer interrupt pending bit of the core. A store to the data register captures one byte and raises `tx_valid` for one clock, which a downstream serializer or test monitor consumes. Every accepted request is answered one clock later on `rsp_ready`/`rsp_rdata`.

Top module: `mmio_periph_top`

## Requirements
- R1: The time register sits at address `0x1000_0000`. A read returns its value at the accepting edge. A write with at least one set bit in `req_wstrb` replaces the bytes whose strobe is set (strobe bit b covers data bits 8b+7..8b) and keeps the others. A write whose strobes are all zero is ignored.
- R2: In every cycle without an effective time write, the time register increases by one and wraps from `0xFFFF_FFFF` to `0`. A time write in the same cycle takes priority over the increment.
- R3: The compare register sits at address `0x1000_0004`. It is read and written like the time register, with the same byte strobe merge, and it never counts.
- R4: `timer_irq` is high exactly when time is greater than or equal to compare in an unsigned comparison of the register values. It stays high until software raises compare above time or rewrites time.
- R5: A write to the data register (`0x1000_1004`) with `req_wstrb[0]` set captures `req_wdata[7:0]` into `tx_byte` and drives `tx_valid` high for exactly the one cycle after the accepting edge. Back-to-back stores give one pulse each. A store with `req_wstrb[0]` clear is ignored. A read of the data register returns the captured byte in bits 7..0 and zero above.
- R6: A read of the status register (`0x1000_1000`) returns 1 in bit 0 when `tx_valid` is low at the accepting edge, 0 when it is high, and zero in bits 31..1. Writes to the status register are ignored.
- R7: Only the four exact word addresses above are mapped. Any other address, whether misaligned, in another offset of the window or outside the window, reads as zero. Writes to such addresses change no register.
- R8: Each cycle with `req_valid` high is accepted. `rsp_ready` is high in the next cycle, with `rsp_rdata` holding the read value, or zero for a write. In a cycle that follows no request, `rsp_ready` is low and `rsp_rdata` is zero.
- R9: While `rst_n` is low at a clock edge, time becomes 0, compare becomes `0xFFFF_FFFF` and the captured byte becomes 0. `tx_valid`, `timer_irq` and `rsp_ready` are low once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Store data |
| req_wstrb | input | 4 | Byte enables of the store |
| rsp_ready | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Load data, zero for stores and idle cycles |
| timer_irq | output | 1 | Machine timer pending level |
| tx_byte | output | 8 | Last captured transmit byte |
| tx_valid | output | 1 | One-cycle pulse per captured byte |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, an 8-bit address window tag of `0x10` and an 8-bit transmit byte. Because the time register is fully writable, the wrap at `0xFFFF_FFFF` and a compare of zero are reached in a few cycles by preloading values, not by waiting for the counter. Randomly ordered stores with random strobes, including stores to the status register and to unmapped addresses, exercise the strobe merge, the priority of a write over the increment, and the status bit read in the cycle of a transmit pulse.

// File: rtl/mmio_plat_pkg.sv
`timescale 1ns/1ps
// Package: shared register selector type for the peripheral register block.
// Assumes one request per cycle; the selector names exactly one register or none.
package mmio_plat_pkg;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_MTIME = 3'd1,
        SEL_MTCMP = 3'd2,
        SEL_USTAT = 3'd3,
        SEL_UDATA = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/mmio_addr_decode.sv
`timescale 1ns/1ps
// Module: mmio_addr_decode
// Maps a byte address onto one of the four registers. It requires an exact
// match of the window tag in the top address bits and of the full offset below
// them. Everything else, misaligned addresses included, yields SEL_NONE.
// Assumes: the offsets are distinct and fit in ADDR_W-WIN_W bits.
module mmio_addr_decode
    import mmio_plat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 8,
    parameter logic [WIN_W-1:0]        WIN_TAG   = 8'h10,
    parameter logic [ADDR_W-WIN_W-1:0] OFF_MTIME = 24'h00_0000,
    parameter logic [ADDR_W-WIN_W-1:0] OFF_MTCMP = 24'h00_0004,
    parameter logic [ADDR_W-WIN_W-1:0] OFF_USTAT = 24'h00_1000,
    parameter logic [ADDR_W-WIN_W-1:0] OFF_UDATA = 24'h00_1004
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int OFF_W = ADDR_W - WIN_W;

    logic             win_hit;
    logic [OFF_W-1:0] offset;

    // Split the address into window tag check and in-window offset.
    always_comb begin
        win_hit = (addr[ADDR_W-1 -: WIN_W] == WIN_TAG);
        offset  = addr[OFF_W-1:0];
    end

    // Select the register whose offset matches exactly.
    always_comb begin
        sel = SEL_NONE;
        if (win_hit) begin
            if (offset == OFF_MTIME)      sel = SEL_MTIME;
            else if (offset == OFF_MTCMP) sel = SEL_MTCMP;
            else if (offset == OFF_USTAT) sel = SEL_USTAT;
            else if (offset == OFF_UDATA) sel = SEL_UDATA;
        end
    end

endmodule

// File: rtl/mmio_mtimer.sv
`timescale 1ns/1ps
// Module: mmio_mtimer
// Free-running time counter plus compare register, each writable with byte
// strobes. An effective time write replaces the increment for that cycle. The
// pending level is an unsigned time >= compare taken from the registers.
// Assumes: TW is a multiple of 8; wr_time/wr_cmp are only raised with a
// nonzero strobe.
module mmio_mtimer #(
    parameter int TW = 32,
    parameter int SW = TW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_time,
    input  logic          wr_cmp,
    input  logic [TW-1:0] wdata,
    input  logic [SW-1:0] wstrb,
    output logic [TW-1:0] mtime,
    output logic [TW-1:0] mtimecmp,
    output logic          irq
);
    logic [TW-1:0] time_merge;
    logic [TW-1:0] cmp_merge;

    // Per-byte merge of store data over the current register contents.
    for (genvar b = 0; b < SW; b++) begin : g_merge
        assign time_merge[b*8 +: 8] = wstrb[b] ? wdata[b*8 +: 8] : mtime[b*8 +: 8];
        assign cmp_merge[b*8 +: 8]  = wstrb[b] ? wdata[b*8 +: 8] : mtimecmp[b*8 +: 8];
    end

    // Time counter: reset to zero, store wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       mtime <= '0;
        else if (wr_time) mtime <= time_merge;
        else              mtime <= mtime + 1'b1;
    end

    // Compare register: reset to all ones so nothing is pending after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      mtimecmp <= '1;
        else if (wr_cmp) mtimecmp <= cmp_merge;
    end

    // Pending level from the registered values.
    always_comb irq = (mtime >= mtimecmp);

    // R2: without a store the counter advances by exactly one.
    a_r2_mtime_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_time |=> mtime == $past(mtime) + 1'b1);

    // R4: pending stays up while neither register is stored and no wrap occurs.
    a_r4_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_time && !wr_cmp && mtime != '1) |=> irq);

    // R9: first cycle out of reset shows the reset values and no pending.
    a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mtime == '0 && mtimecmp == '1 && !irq));

endmodule

// File: rtl/mmio_uart_tx.sv
`timescale 1ns/1ps
// Module: mmio_uart_tx
// Captures a byte on each data store and raises a one-cycle valid pulse.
// Reports idle (transmitter ready) whenever no pulse is being presented.
// Assumes: the consumer takes the byte in the pulse cycle; no queueing.
module mmio_uart_tx #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic [BW-1:0] wbyte,
    output logic [BW-1:0] tx_byte,
    output logic          tx_valid,
    output logic          tx_idle
);
    // Byte holding register: cleared by reset, loaded on each data store.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_byte <= '0;
        else if (wr_data) tx_byte <= wbyte;
    end

    // Valid pulse: high for the single cycle after each accepted data store.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_valid <= 1'b0;
        else        tx_valid <= wr_data;
    end

    // Ready indication for the status register.
    always_comb tx_idle = !tx_valid;

    // R5: a pulse never lasts past one cycle unless a new store arrived.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> (!tx_valid || $past(wr_data)));

    // R5: the byte only changes when a pulse accompanies it.
    a_r5_byte_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> $stable(tx_byte) || !$past(rst_n));

endmodule

// File: rtl/mmio_periph_top.sv
`timescale 1ns/1ps
// Module: mmio_periph_top
// Peripheral register block for the 0x10xx_xxxx window: time, compare,
// transmit status and transmit data. Each request is accepted in its cycle;
// stores take effect at that edge, and the response (read data or zero) is
// registered and presented one cycle later.
// Assumes: at most one request per cycle, DATA_W a multiple of 8, TX_W <= 8
// so strobe bit 0 covers the whole byte.
module mmio_periph_top
    import mmio_plat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TX_W   = 8,
    parameter int WIN_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_wstrb,
    output logic                rsp_ready,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                timer_irq,
    output logic [TX_W-1:0]     tx_byte,
    output logic                tx_valid
);
    localparam int SW = DATA_W / 8;

    reg_sel_e          sel;
    logic              do_write;
    logic              do_read;
    logic              wr_time;
    logic              wr_cmp;
    logic              wr_data;
    logic              tx_idle;
    logic [DATA_W-1:0] mtime;
    logic [DATA_W-1:0] mtimecmp;
    logic [DATA_W-1:0] rd_word;

    mmio_addr_decode #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W)
    ) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    // Qualify the request into per-register write strobes.
    always_comb begin
        do_write = req_valid && req_write;
        do_read  = req_valid && !req_write;
        wr_time  = do_write && (sel == SEL_MTIME) && (|req_wstrb);
        wr_cmp   = do_write && (sel == SEL_MTCMP) && (|req_wstrb);
        wr_data  = do_write && (sel == SEL_UDATA) && req_wstrb[0];
    end

    mmio_mtimer #(
        .TW (DATA_W),
        .SW (SW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_time  (wr_time),
        .wr_cmp   (wr_cmp),
        .wdata    (req_wdata),
        .wstrb    (req_wstrb),
        .mtime    (mtime),
        .mtimecmp (mtimecmp),
        .irq      (timer_irq)
    );

    mmio_uart_tx #(
        .BW (TX_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .wbyte    (req_wdata[TX_W-1:0]),
        .tx_byte  (tx_byte),
        .tx_valid (tx_valid),
        .tx_idle  (tx_idle)
    );

    // Read multiplexer over the register values before the accepting edge.
    always_comb begin
        case (sel)
            SEL_MTIME: rd_word = mtime;
            SEL_MTCMP: rd_word = mtimecmp;
            SEL_USTAT: rd_word = {{(DATA_W-1){1'b0}}, tx_idle};
            SEL_UDATA: rd_word = {{(DATA_W-TX_W){1'b0}}, tx_byte};
            default:   rd_word = '0;
        endcase
    end

    // Response register: one cycle after each request, zero data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ready <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ready <= req_valid;
            rsp_rdata <= do_read ? rd_word : '0;
        end
    end

    // R8: every accepted request is answered in the next cycle.
    a_r8_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);

    // R8: no request means a quiet response in the next cycle.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_ready && rsp_rdata == '0));

    // R6: status answers carry nothing above bit 0.
    a_r6_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (do_read && sel == SEL_USTAT) |=> rsp_rdata[DATA_W-1:1] == '0);

    // R7: unmapped reads answer zero.
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (do_read && sel == SEL_NONE) |=> rsp_rdata == '0);

    // R7: unmapped stores leave the compare register and byte untouched.
    a_r7_unmapped_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && sel == SEL_NONE) |=> ($stable(mtimecmp) && $stable(tx_byte)));

endmodule

// File: tb/mmio_periph_top_tb.sv
`timescale 1ns/1ps
// Bench for mmio_periph_top: directed corner cases then seeded random traffic,
// all compared against a bench-side register model.
module mmio_periph_top_tb_top;

    localparam logic [31:0] A_TIME = 32'h1000_0000;
    localparam logic [31:0] A_CMP  = 32'h1000_0004;
    localparam logic [31:0] A_STAT = 32'h1000_1000;
    localparam logic [31:0] A_DATA = 32'h1000_1004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_wstrb = '0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;
    logic        timer_irq;
    logic [7:0]  tx_byte;
    logic        tx_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_time, m_cmp;
    logic [7:0]  m_byte;
    logic        m_txv;

    mmio_periph_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .timer_irq(timer_irq),
        .tx_byte(tx_byte), .tx_valid(tx_valid)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] s);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    function automatic string addr_tag(input logic [31:0] a);
        case (a)
            A_TIME:  return "R1";
            A_CMP:   return "R3";
            A_STAT:  return "R6";
            A_DATA:  return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, advance the model at the rising
    // edge, compare all outputs at the next falling edge.
    task automatic cyc(input logic v, input logic w, input logic [31:0] a,
                       input logic [31:0] d, input logic [3:0] s, input string tag);
        logic [31:0] exp_rd;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_wstrb = s;
        exp_rd = '0;
        if (v && !w) begin
            case (a)
                A_TIME:  exp_rd = m_time;
                A_CMP:   exp_rd = m_cmp;
                A_STAT:  exp_rd = {31'b0, !m_txv};
                A_DATA:  exp_rd = {24'b0, m_byte};
                default: exp_rd = '0;
            endcase
        end
        @(posedge clk);
        if (v && w && a == A_TIME && s != 4'b0) m_time = merge(m_time, d, s);
        else                                     m_time = m_time + 32'd1;
        if (v && w && a == A_CMP && s != 4'b0)   m_cmp = merge(m_cmp, d, s);
        m_txv = v && w && a == A_DATA && s[0];
        if (m_txv) m_byte = d[7:0];
        @(negedge clk);
        check("R8", "rsp_ready", {31'b0, rsp_ready}, {31'b0, v});
        check(tag, "rsp_rdata", rsp_rdata, exp_rd);
        check("R4", "timer_irq", {31'b0, timer_irq}, {31'b0, m_time >= m_cmp});
        check("R5", "tx_valid", {31'b0, tx_valid}, {31'b0, m_txv});
        check("R5", "tx_byte", {24'b0, tx_byte}, {24'b0, m_byte});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, '0, '0, "R8");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_time = '0; m_cmp = '1; m_byte = '0; m_txv = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset values at the ports.
        check("R9", "tx_valid in reset", {31'b0, tx_valid}, 32'd0);
        check("R9", "rsp_ready in reset", {31'b0, rsp_ready}, 32'd0);
        check("R9", "timer_irq in reset", {31'b0, timer_irq}, 32'd0);
        check("R9", "tx_byte in reset", {24'b0, tx_byte}, 32'd0);
        rst_n = 1'b1;
        // First cycle out of reset: time was 0 at the accepting edge.
        cyc(1'b1, 1'b0, A_TIME, '0, '0, "R9");
        cyc(1'b1, 1'b0, A_CMP,  '0, '0, "R9");
        cyc(1'b1, 1'b0, A_DATA, '0, '0, "R9");
        cyc(1'b1, 1'b0, A_STAT, '0, '0, "R6");

        // R2/R4: preload, count up into the compare value.
        cyc(1'b1, 1'b1, A_TIME, 32'd100, 4'hF, "R1");
        cyc(1'b1, 1'b1, A_CMP,  32'd110, 4'hF, "R3");
        idle(12);
        cyc(1'b1, 1'b0, A_TIME, '0, '0, "R2");
        // R4: raising compare clears pending.
        cyc(1'b1, 1'b1, A_CMP, 32'h0001_0000, 4'hF, "R4");
        // R1: partial strobe merge; zero-strobe store ignored.
        cyc(1'b1, 1'b1, A_TIME, 32'hDEAD_AB77, 4'b0010, "R1");
        cyc(1'b1, 1'b1, A_TIME, 32'h1234_5678, 4'b0000, "R1");
        cyc(1'b1, 1'b0, A_TIME, '0, '0, "R1");
        // R2: wrap at the top; compare zero keeps pending through it.
        cyc(1'b1, 1'b1, A_CMP,  32'd0, 4'hF, "R3");
        cyc(1'b1, 1'b1, A_TIME, 32'hFFFF_FFFE, 4'hF, "R2");
        idle(3);
        cyc(1'b1, 1'b0, A_TIME, '0, '0, "R2");
        cyc(1'b1, 1'b1, A_CMP, 32'hFFFF_FFFF, 4'hF, "R3");
        // R4: time rewritten below compare.
        cyc(1'b1, 1'b1, A_TIME, 32'hFFFF_FFF0, 4'hF, "R4");
        cyc(1'b1, 1'b1, A_TIME, 32'd5, 4'hF, "R4");

        // R5/R6: byte capture, status during the pulse, back-to-back pulses.
        cyc(1'b1, 1'b1, A_DATA, 32'hFFFF_FF5A, 4'b0001, "R5");
        cyc(1'b1, 1'b0, A_STAT, '0, '0, "R6");
        cyc(1'b1, 1'b0, A_STAT, '0, '0, "R6");
        cyc(1'b1, 1'b1, A_DATA, 32'h0000_00C3, 4'hF, "R5");
        cyc(1'b1, 1'b1, A_DATA, 32'h0000_003C, 4'hF, "R5");
        cyc(1'b1, 1'b0, A_DATA, '0, '0, "R5");
        cyc(1'b1, 1'b1, A_DATA, 32'h0000_0099, 4'b1110, "R5");
        cyc(1'b1, 1'b1, A_STAT, 32'hFFFF_FFFF, 4'hF, "R6");
        cyc(1'b1, 1'b0, A_DATA, '0, '0, "R5");

        // R7: unmapped stores then reads.
        cyc(1'b1, 1'b1, 32'h1000_0008, 32'h1111_1111, 4'hF, "R7");
        cyc(1'b1, 1'b1, 32'h1000_0005, 32'h2222_2222, 4'hF, "R7");
        cyc(1'b1, 1'b1, 32'h2000_0004, 32'h3333_3333, 4'hF, "R7");
        cyc(1'b1, 1'b1, 32'h1100_1004, 32'h4444_4444, 4'hF, "R7");
        cyc(1'b1, 1'b0, 32'h1000_0008, '0, '0, "R7");
        cyc(1'b1, 1'b0, 32'h0000_0000, '0, '0, "R7");
        cyc(1'b1, 1'b0, 32'h1000_1001, '0, '0, "R7");
        cyc(1'b1, 1'b0, A_CMP,  '0, '0, "R7");
        cyc(1'b1, 1'b0, A_DATA, '0, '0, "R7");

        // Seeded random traffic over mapped and unmapped addresses.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] d;
            logic [3:0]  s;
            case ($urandom_range(0, 7))
                0: a = A_TIME;
                1: a = A_CMP;
                2: a = A_STAT;
                3: a = A_DATA;
                4: a = 32'h1000_000C;
                5: a = 32'h1000_0002;
                6: a = 32'h3000_0000;
                default: a = A_DATA;
            endcase
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d = m_time + $urandom_range(0, 20);
            s = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 2) == 0) s = 4'hF;
            cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), a, d, s, addr_tag(a));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as one failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule